// File: doc/BRIEF.md
# Receive Packet Page Ring Manager

This block places incoming packet bytes into a circular receive area of local memory. The area is made of 256-byte pages, bounded by a first page and a stop page that the host programs. The block keeps a write page (where the next packet will start) and a host-owned read page (the boundary). For every byte it produces a memory write command and moves from page to page as the packet grows. It wraps from the stop page back to the first page, and it refuses to run into the boundary.

Each packet is stored behind a 4-byte slot at the start of its first page. Data bytes fill the area from offset 4 onward, with the check bytes included as ordinary data. Once a good end-of-packet arrives, the block returns to the slot and writes the link to the following packet, the status byte and the 16-bit byte count. It then moves its write page forward and raises a done pulse. A packet that ends bad, or that would overrun the boundary, is dropped and its pages are handed back. In the overrun case an overwrite pulse is raised.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset all four page registers read 0, `rx_ready` is 1, and `mem_we`, `irq_rx_done` and `irq_overwrite` are 0.
- R2: The first byte of a packet is written at offset 4 of the current write page, and each further byte goes to the next address. Each write appears on `mem_we`/`mem_addr`/`mem_wdata` one cycle after the byte is taken.
- R3: A byte at offset 255 moves writing to offset 0 of the next page. The page after the one just below the stop page is the first page of the ring.
- R4: A packet claims a new page when a byte lands at offset 255 or when its last byte arrives. If the claimed page equals the boundary, the packet is aborted. `irq_overwrite` pulses for one cycle, later bytes up to end-of-packet are not written, no header is written and the write page is left unchanged.
- R5: For an accepted packet, offsets 0 to 3 of its first page are written with the link page, the status byte (`rx_status` taken with the last byte), then the count low byte and the count high byte. The count is the number of bytes received.
- R6: On acceptance, the link page and the new write page are the page after the last page used, wrapped per R3. The write page changes at no other time except through a host write.
- R7: `irq_rx_done` pulses for one cycle together with the last header write, and only for an accepted packet.
- R8: A packet whose last byte comes with `rx_good` = 0 gets no header and leaves the write page unchanged, so the next packet reuses the same first page.
- R9: `rx_ready` is 0 during the four header-write cycles. Bytes offered in those cycles are ignored.
- R10: When `cfg_we` is high, `cfg_wdata` loads the register picked by `cfg_sel`: 0 first page, 1 stop page, 2 write page, 3 boundary. A write to the write page is visible on `cur_page_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | page register write strobe |
| cfg_sel | input | 2 | page register select |
| cfg_wdata | input | PG_W | page register write value |
| rx_valid | input | 1 | receive byte valid |
| rx_data | input | 8 | receive byte |
| rx_eop | input | 1 | byte is the last of the packet |
| rx_good | input | 1 | packet good, taken with the last byte |
| rx_status | input | 8 | status byte for the header, taken with the last byte |
| rx_ready | output | 1 | block can take bytes |
| mem_we | output | 1 | memory byte write |
| mem_addr | output | PG_W+OFF_W | memory byte address |
| mem_wdata | output | 8 | memory byte data |
| irq_rx_done | output | 1 | packet stored pulse |
| irq_overwrite | output | 1 | ring full abort pulse |
| cur_page_o | output | PG_W | current write page |

## Verification
The bench sweeps every packet length from 1 to 300 bytes, each starting where the previous one ended, so that the first byte, the last byte and the page crossings fall on every offset. These runs separate off-by-one faults in the page crossing, in the wrap to the first page and in the link value. Every seventh length ends bad, which shows that pages are handed back and the next packet reuses the first page. A block of lengths around two pages and a block around the four-page ring size, with the boundary at the write page, tell an end-of-packet claim apart from an offset-255 claim against the boundary. One run with the boundary two pages ahead aborts in the middle of the packet and proves that the remaining bytes are dropped. Bytes offered during the header cycles and a host write to the write page complete the picture.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // slot reserved in front of each stored packet
  localparam int HDR_BYTES = 4;
  localparam int HIDX_W    = $clog2(HDR_BYTES);
  localparam int CNT_W     = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    CFG_FIRST = 2'd0,
    CFG_STOP  = 2'd1,
    CFG_WPAGE = 2'd2,
    CFG_BOUND = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PG_W-1:0] cfg_wdata,
  input  logic            hw_cur_we,
  input  logic [PG_W-1:0] hw_cur_val,
  output logic [PG_W-1:0] pg_start,
  output logic [PG_W-1:0] pg_stop,
  output logic [PG_W-1:0] pg_cur,
  output logic [PG_W-1:0] pg_bnd
);
  localparam int NREG = 4;

  logic [PG_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic            en;
    logic [PG_W-1:0] d;
    always_comb begin
      en = cfg_we && (cfg_sel == 2'(g));
      d  = cfg_wdata;
      // the block's own page advance wins over a host write in the same cycle
      if ((g == int'(CFG_WPAGE)) && hw_cur_we) begin
        en = 1'b1;
        d  = hw_cur_val;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= '0;
      else if (en) q[g] <= d;
    end
  end

  assign pg_start = q[int'(CFG_FIRST)];
  assign pg_stop  = q[int'(CFG_STOP)];
  assign pg_cur   = q[int'(CFG_WPAGE)];
  assign pg_bnd   = q[int'(CFG_BOUND)];
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
  parameter int PG_W = 8
) (
  input  logic [PG_W-1:0] pg,
  input  logic [PG_W-1:0] pg_start,
  input  logic [PG_W-1:0] pg_stop,
  output logic [PG_W-1:0] nxt
);
  logic [PG_W-1:0] inc;
  always_comb begin
    inc = pg + PG_W'(1);
    nxt = (inc == pg_stop) ? pg_start : inc;
  end
endmodule

// File: rtl/rxr_ctl.sv
module rxr_ctl
  import rxr_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_eop,
  input  logic                  rx_good,
  input  logic [7:0]            rx_status,
  input  logic [PG_W-1:0]       pg_cur,
  input  logic [PG_W-1:0]       pg_bnd,
  input  logic [PG_W-1:0]       claim_pg,
  output logic [PG_W-1:0]       page_now,
  output logic                  cur_we,
  output logic [PG_W-1:0]       cur_val,
  output logic                  rx_ready,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  irq_done,
  output logic                  irq_ovw
);
  localparam int ADDR_W = PG_W + OFF_W;
  localparam logic [OFF_W-1:0] OFF_LAST = '1;
  localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(HDR_BYTES);
  localparam logic [HIDX_W-1:0] HIDX_END = HIDX_W'(HDR_BYTES - 1);

  rx_state_e         st_q, st_d;
  logic [ADDR_W-1:0] wp_q, wp_d;
  logic [PG_W-1:0]   sp_q, sp_d;
  logic [PG_W-1:0]   np_q, np_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        stat_q, stat_d;
  logic [HIDX_W-1:0] hi_q, hi_d;
  logic              mwe_q, mwe_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic [7:0]        mdat_q, mdat_d;
  logic              done_q, done_d;
  logic              ovw_q, ovw_d;

  logic [ADDR_W-1:0] byte_addr;
  logic              claim, full;
  logic [7:0]        hdr_byte;

  // address of the byte offered now: a fresh packet starts past the slot
  assign byte_addr = (st_q == ST_IDLE) ? {pg_cur, OFF_DATA} : wp_q;
  assign page_now  = byte_addr[ADDR_W-1:OFF_W];
  assign claim     = (byte_addr[OFF_W-1:0] == OFF_LAST) || rx_eop;
  assign full      = claim && (claim_pg == pg_bnd);

  always_comb begin
    unique case (hi_q)
      2'd0:    hdr_byte = 8'(np_q);
      2'd1:    hdr_byte = stat_q;
      2'd2:    hdr_byte = cnt_q[7:0];
      default: hdr_byte = cnt_q[15:8];
    endcase
  end

  always_comb begin
    st_d    = st_q;
    wp_d    = wp_q;
    sp_d    = sp_q;
    np_d    = np_q;
    cnt_d   = cnt_q;
    stat_d  = stat_q;
    hi_d    = hi_q;
    mwe_d   = 1'b0;
    maddr_d = maddr_q;
    mdat_d  = mdat_q;
    done_d  = 1'b0;
    ovw_d   = 1'b0;
    cur_we  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_RECV: begin
        if (rx_valid) begin
          mwe_d   = 1'b1;
          maddr_d = byte_addr;
          mdat_d  = rx_data;
          cnt_d   = (st_q == ST_IDLE) ? CNT_W'(1) : cnt_q + CNT_W'(1);
          if (st_q == ST_IDLE) sp_d = pg_cur;
          if (full) begin
            ovw_d = 1'b1;
            st_d  = rx_eop ? ST_IDLE : ST_DROP;
          end else if (rx_eop) begin
            if (rx_good) begin
              st_d   = ST_HDR;
              np_d   = claim_pg;
              stat_d = rx_status;
              hi_d   = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            st_d = ST_RECV;
            wp_d = (byte_addr[OFF_W-1:0] == OFF_LAST) ?
                   {claim_pg, {OFF_W{1'b0}}} : byte_addr + ADDR_W'(1);
          end
        end
      end
      ST_DROP: begin
        if (rx_valid && rx_eop) st_d = ST_IDLE;
      end
      ST_HDR: begin
        mwe_d   = 1'b1;
        maddr_d = {sp_q, OFF_W'(hi_q)};
        mdat_d  = hdr_byte;
        hi_d    = hi_q + HIDX_W'(1);
        if (hi_q == HIDX_END) begin
          st_d   = ST_IDLE;
          cur_we = 1'b1;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wp_q    <= '0;
      sp_q    <= '0;
      np_q    <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
      hi_q    <= '0;
      mwe_q   <= 1'b0;
      maddr_q <= '0;
      mdat_q  <= '0;
      done_q  <= 1'b0;
      ovw_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      wp_q    <= wp_d;
      sp_q    <= sp_d;
      np_q    <= np_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      hi_q    <= hi_d;
      mwe_q   <= mwe_d;
      maddr_q <= maddr_d;
      mdat_q  <= mdat_d;
      done_q  <= done_d;
      ovw_q   <= ovw_d;
    end
  end

  assign cur_val   = np_q;
  assign rx_ready  = (st_q != ST_HDR);
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mdat_q;
  assign irq_done  = done_q;
  assign irq_ovw   = ovw_q;
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [PG_W-1:0]       cfg_wdata,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_eop,
  input  logic                  rx_good,
  input  logic [7:0]            rx_status,
  output logic                  rx_ready,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  irq_rx_done,
  output logic                  irq_overwrite,
  output logic [PG_W-1:0]       cur_page_o
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [PG_W-1:0] pg_start, pg_stop, pg_cur, pg_bnd;
  logic [PG_W-1:0] page_now, claim_pg, cur_val;
  logic            cur_we;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rxr_regs #(.PG_W(PG_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .hw_cur_we  (cur_we),
    .hw_cur_val (cur_val),
    .pg_start   (pg_start),
    .pg_stop    (pg_stop),
    .pg_cur     (pg_cur),
    .pg_bnd     (pg_bnd)
  );

  rxr_next_page #(.PG_W(PG_W)) i_next (
    .pg       (page_now),
    .pg_start (pg_start),
    .pg_stop  (pg_stop),
    .nxt      (claim_pg)
  );

  rxr_ctl #(.PG_W(PG_W), .OFF_W(OFF_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_eop    (rx_eop),
    .rx_good   (rx_good),
    .rx_status (rx_status),
    .pg_cur    (pg_cur),
    .pg_bnd    (pg_bnd),
    .claim_pg  (claim_pg),
    .page_now  (page_now),
    .cur_we    (cur_we),
    .cur_val   (cur_val),
    .rx_ready  (rx_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq_done  (irq_rx_done),
    .irq_ovw   (irq_overwrite)
  );

  assign cur_page_o = pg_cur;
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [1:0]            cfg_sel,
  input logic                  mem_we,
  input logic [PG_W+OFF_W-1:0] mem_addr,
  input logic                  irq_rx_done,
  input logic                  irq_overwrite,
  input logic                  rx_ready,
  input logic [PG_W-1:0]       pg_start,
  input logic [PG_W-1:0]       pg_stop,
  input logic [PG_W-1:0]       pg_cur
);
  logic [PG_W-1:0] wr_page;
  assign wr_page = mem_addr[PG_W+OFF_W-1:OFF_W];

  AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (pg_start < pg_stop) && (pg_cur >= pg_start) && (pg_cur < pg_stop))
      |-> (wr_page >= pg_start) && (wr_page < pg_stop)); // R3

  AST_DONE_WITH_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_done |-> mem_we && (mem_addr[OFF_W-1:0] == OFF_W'(3)) && !$past(rx_ready)); // R7

  AST_WPAGE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pg_cur) |-> irq_rx_done || $past(cfg_we && (cfg_sel == 2'd2))); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rx_done, irq_overwrite})); // R4

  AST_OVW_KEEPS_WPAGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overwrite |-> $stable(pg_cur) || $past(cfg_we && (cfg_sel == 2'd2))); // R4

  AST_HDR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> mem_we); // R9
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cfg_we        (cfg_we),
  .cfg_sel       (cfg_sel),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .irq_rx_done   (irq_rx_done),
  .irq_overwrite (irq_overwrite),
  .rx_ready      (rx_ready),
  .pg_start      (pg_start),
  .pg_stop       (pg_stop),
  .pg_cur        (pg_cur)
);

// File: tb/test_rx_ring_mgr.sv
module test_rx_ring_mgr;
  localparam int PG_W   = 8;
  localparam int OFF_W  = 8;
  localparam int PFIRST = 16'h10;
  localparam int PSTOP  = 16'h14;
  localparam int BASE   = PFIRST * 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        rx_valid, rx_eop, rx_good;
  logic [7:0]  rx_data, rx_status;
  logic        rx_ready, mem_we, irq_rx_done, irq_overwrite;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page_o;

  always #5 clk = ~clk;

  rx_ring_mgr #(.PG_W(PG_W), .OFF_W(OFF_W)) i_rx_ring_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
    .rx_status(rx_status), .rx_ready(rx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_rx_done(irq_rx_done), .irq_overwrite(irq_overwrite),
    .cur_page_o(cur_page_o)
  );

  int total = 0, bad = 0;
  int wcount = 0, ndone = 0, novw = 0, nout = 0;
  int bnd;
  logic [7:0] mem [0:1023];
  int eaddr [0:2047];

  // memory model and pulse counters, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        wcount++;
        if (int'(mem_addr) >= BASE && int'(mem_addr) < PSTOP * 256)
          mem[int'(mem_addr) - BASE] = mem_wdata;
        else
          nout++;
      end
      if (irq_rx_done)   ndone++;
      if (irq_overwrite) novw++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int wrap(input int p);
    return (p + 1 == PSTOP) ? PFIRST : p + 1;
  endfunction

  task automatic send_pkt(input int n, input bit good, input int seed, input bit poke);
    int cur0, pg, off, abort_i, np, written, w0, d0, o0, miss;
    bit acc;
    cur0 = int'(cur_page_o);
    pg = cur0; off = 4; abort_i = -1; np = 0;
    for (int i = 0; i < n; i++) begin
      eaddr[i] = pg * 256 + off;
      if (off == 255 || i == n - 1) begin
        np = wrap(pg);
        if (np == bnd) begin abort_i = i; break; end
        if (off == 255) begin pg = np; off = 0; end else off++;
      end else off++;
    end
    written = (abort_i >= 0) ? abort_i + 1 : n;
    acc = (abort_i < 0) && good;
    w0 = wcount; d0 = ndone; o0 = novw;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(seed + i); rx_eop = (i == n - 1);
      rx_good = good; rx_status = 8'(n) ^ 8'h5A;
    end
    @(negedge clk);
    if (poke && acc) begin
      chk(rx_ready == 1'b0, "R9", int'(rx_ready), 0, "ready during header");
      rx_valid = 1'b1; rx_data = 8'hEE; rx_eop = 1'b1;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eop = 1'b0;
    repeat (8) @(negedge clk);
    chk(wcount - w0 == written + (acc ? 4 : 0), "R4 R8 R9", wcount - w0,
        written + (acc ? 4 : 0), $sformatf("write count len=%0d", n));
    miss = 0;
    for (int i = 0; i < written; i++)
      if (mem[eaddr[i] - BASE] !== 8'(seed + i)) miss++;
    chk(miss == 0 && nout == 0, "R2 R3", miss, 0, $sformatf("data bytes len=%0d", n));
    chk(novw - o0 == ((abort_i >= 0) ? 1 : 0), "R4", novw - o0, (abort_i >= 0) ? 1 : 0,
        $sformatf("overwrite pulse len=%0d", n));
    chk(ndone - d0 == (acc ? 1 : 0), "R7", ndone - d0, acc ? 1 : 0,
        $sformatf("done pulse len=%0d", n));
    if (acc) begin
      chk(mem[cur0 * 256 - BASE] == 8'(np), "R6", int'(mem[cur0 * 256 - BASE]), np, "link byte");
      chk(mem[cur0 * 256 + 1 - BASE] == (8'(n) ^ 8'h5A), "R5",
          int'(mem[cur0 * 256 + 1 - BASE]), int'(8'(n) ^ 8'h5A), "status byte");
      chk(mem[cur0 * 256 + 2 - BASE] == 8'(n), "R5", int'(mem[cur0 * 256 + 2 - BASE]),
          n % 256, "count low");
      chk(mem[cur0 * 256 + 3 - BASE] == 8'(n >> 8), "R5", int'(mem[cur0 * 256 + 3 - BASE]),
          n / 256, "count high");
      chk(int'(cur_page_o) == np, "R6", int'(cur_page_o), np, "write page advance");
    end else begin
      chk(int'(cur_page_o) == cur0, (abort_i >= 0) ? "R4" : "R8", int'(cur_page_o), cur0,
          "write page kept");
    end
    // host consumes everything stored so far
    cfg(2'd3, int'(cur_page_o));
    bnd = int'(cur_page_o);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'd0;
    rx_valid = 1'b0; rx_eop = 1'b0; rx_good = 1'b0; rx_data = 8'd0; rx_status = 8'd0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_page_o == 8'd0, "R1", int'(cur_page_o), 0, "write page after reset");
    chk(rx_ready == 1'b1, "R1", int'(rx_ready), 1, "ready after reset");
    chk(mem_we == 1'b0 && wcount == 0, "R1", wcount, 0, "no writes after reset");
    chk(irq_rx_done == 1'b0 && irq_overwrite == 1'b0, "R1",
        int'({irq_rx_done, irq_overwrite}), 0, "flags after reset");
    // R10 configuration
    cfg(2'd0, PFIRST);
    cfg(2'd1, PSTOP);
    cfg(2'd2, 16'h12);
    chk(int'(cur_page_o) == 16'h12, "R10", int'(cur_page_o), 16'h12, "host write page");
    cfg(2'd2, PFIRST);
    cfg(2'd3, PFIRST);
    bnd = PFIRST;
    chk(int'(cur_page_o) == PFIRST, "R10", int'(cur_page_o), PFIRST, "host write page back");
    // sweep of lengths, every seventh ends bad (R8), header-cycle pokes (R9)
    for (int len = 1; len <= 300; len++)
      send_pkt(len, (len % 7) != 0, len * 3, (len == 50) || (len == 251) || (len == 252));
    for (int len = 500; len <= 520; len++)
      send_pkt(len, 1'b1, len, 1'b0);
    // around the whole ring: claims reach the boundary from 765 bytes on (R4)
    for (int len = 760; len <= 770; len++)
      send_pkt(len, 1'b1, len + 7, 1'b0);
    // boundary two pages ahead: abort in mid packet, tail dropped (R4)
    cfg(2'd3, wrap(wrap(int'(cur_page_o))));
    bnd = wrap(wrap(int'(cur_page_o)));
    send_pkt(600, 1'b1, 11, 1'b0);
    send_pkt(100, 1'b1, 5, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule